// File: doc/BRIEF.md
# Block-Aligned Jump Entry Validator

This block decides whether a jump target lands on a genuine instruction start. Code is cut into aligned blocks of eight words, and the first word of every block always begins an instruction. Instruction framing therefore restarts at every block boundary. To judge a target, the block needs only the words of its own block that come before the target, and never more than seven of them.

A request carries all eight words of the target's block and the word offset of the target inside that block. Starting from word 0, the block walks the instruction lengths. It finds the instruction that starts at or covers the target, then returns a pass flag and a two-bit fault code. There are two faults. The first is entry into the middle of an instruction. The second is an instruction that would extend past the last word of the block. Requests and responses use a valid/ready handshake with one result in flight. The result appears in the cycle after the request is accepted, and the request side stays blocked until the result has been taken.

Top module: `jump_entry_check`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) makes `rsp_valid` high after that edge. While `rsp_valid` is high, `req_ready` is low. A response that is not taken keeps `rsp_ok` and `rsp_fault` unchanged until `rsp_ready` is seen high.
- R3: The length of an instruction comes from bits [31:30] of its first word. Codes 00 and 01 mean one word, 10 means two words and 11 means three words. The other bits of the word have no effect.
- R4: A target at offset 0 is always legal: `rsp_ok`=1 and `rsp_fault`=00, whatever the words hold.
- R5: A target at an instruction start, where the instruction at that start ends at or before word 7, gives `rsp_ok`=1 and `rsp_fault`=00.
- R6: A target that lies after the first word of an instruction, where that instruction ends at or before word 7, gives `rsp_ok`=0 and `rsp_fault`=01 (mid-instruction entry).
- R7: If the instruction that starts at or covers the target would run past word 7, the result is `rsp_ok`=0 and `rsp_fault`=10 (block overrun). This fault wins over mid-instruction entry. The code 11 is never produced.
- R8: Framing starts at word 0 of the block. Words after the target have no effect on the result.
- R9: `rsp_ok` is 1 exactly when `rsp_fault` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_words | input | BLK_WORDS*WORD_W | Words of the target's block, word 0 in the low bits |
| req_offset | input | $clog2(BLK_WORDS) | Word offset of the jump target within the block |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ok | output | 1 | Target is a legal entry |
| rsp_fault | output | 2 | 00 none, 01 mid-instruction entry, 10 block overrun |

## Verification
The hardest case to reach is an instruction that both covers the target and overruns the block. To get there, the stimulus has to chain lengths so that a three-word or two-word instruction starts on word 6 or 7, and then aim at a word inside it. The vectors build such chains on purpose: 3+3 followed by a 3 starting at word 6, and seven one-word codes followed by a 2 at word 7. Only then do they aim at that word. Separate vectors keep the words before the target fixed and change the words after it and the low bits of every word, which shows those bits have no effect. A directed test holds back `rsp_ready` for several cycles to check that the held result does not change.

// File: rtl/jev_pkg.sv
package jev_pkg;
   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_MID     = 2'b01,
      FLT_OVERRUN = 2'b10
   } fault_e;

   // length in words from the two-bit length code
   function automatic logic [1:0] code_to_len(input logic [1:0] code);
      code_to_len = code[1] ? (code[0] ? 2'd3 : 2'd2) : 2'd1;
   endfunction
endpackage

// File: rtl/jev_len_decode.sv
module jev_len_decode #(
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 8,
   parameter int CODE_LSB  = 30
) (
   input  logic [BLK_WORDS*WORD_W-1:0] words,
   output logic [2*BLK_WORDS-1:0]      lens
);
   import jev_pkg::*;

   if (CODE_LSB + 2 > WORD_W) begin : g_bad_code_pos
      $error("length code does not fit in the word");
   end

   for (genvar i = 0; i < BLK_WORDS; i++) begin : g_word
      logic [1:0] code;
      assign code          = words[i*WORD_W + CODE_LSB +: 2];
      assign lens[2*i +: 2] = code_to_len(code);
   end
endmodule

// File: rtl/jev_frame_scan.sv
module jev_frame_scan #(
   parameter int BLK_WORDS = 8,
   parameter int MAX_LEN   = 3
) (
   input  logic [2*BLK_WORDS-1:0] lens,
   output logic [BLK_WORDS-1:0]   starts
);
   // word 0 always opens an instruction; framing restarts each block
   assign starts[0] = 1'b1;

   for (genvar i = 1; i < BLK_WORDS; i++) begin : g_pos
      logic [MAX_LEN-1:0] hit;
      for (genvar k = 1; k <= MAX_LEN; k++) begin : g_back
         if (i - k >= 0) begin : g_in
            assign hit[k-1] = starts[i-k] && (lens[2*(i-k) +: 2] == 2'(k));
         end else begin : g_out
            assign hit[k-1] = 1'b0;
         end
      end
      assign starts[i] = |hit;
   end
endmodule

// File: rtl/jev_classify.sv
module jev_classify #(
   parameter int BLK_WORDS = 8,
   localparam int OFS_W    = $clog2(BLK_WORDS)
) (
   input  logic [2*BLK_WORDS-1:0] lens,
   input  logic [BLK_WORDS-1:0]   starts,
   input  logic [OFS_W-1:0]       target,
   output jev_pkg::fault_e        fault
);
   import jev_pkg::*;

   localparam int END_W = OFS_W + 2;

   logic [OFS_W-1:0] land;
   logic [END_W-1:0] land_end;

   // landing instruction: last start at or before the target
   always_comb begin
      land = '0;
      for (int j = 0; j < BLK_WORDS; j++) begin
         if (starts[j] && (OFS_W'(j) <= target)) land = OFS_W'(j);
      end
   end

   assign land_end = END_W'(land) + END_W'(lens[2*land +: 2]);

   always_comb begin
      if (target == '0)                        fault = FLT_NONE;
      else if (land_end > END_W'(BLK_WORDS))   fault = FLT_OVERRUN;
      else if (land != target)                 fault = FLT_MID;
      else                                     fault = FLT_NONE;
   end
endmodule

// File: rtl/jump_entry_check.sv
module jump_entry_check #(
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 8,
   parameter int CODE_LSB  = 30,
   localparam int OFS_W    = $clog2(BLK_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [BLK_WORDS*WORD_W-1:0] req_words,
   input  logic [OFS_W-1:0]            req_offset,
   output logic                        rsp_valid,
   input  logic                        rsp_ready,
   output logic                        rsp_ok,
   output logic [1:0]                  rsp_fault
);
   import jev_pkg::*;

   if (BLK_WORDS < 4 || (1 << OFS_W) != BLK_WORDS) begin : g_bad_blk
      $error("BLK_WORDS must be a power of two of at least 4");
   end

   logic [2*BLK_WORDS-1:0] lens;
   logic [BLK_WORDS-1:0]   starts;
   fault_e                 fault_c;
   logic                   accept;

   jev_len_decode #(
      .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .CODE_LSB(CODE_LSB)
   ) u_len (
      .words(req_words), .lens(lens)
   );

   jev_frame_scan #(
      .BLK_WORDS(BLK_WORDS), .MAX_LEN(3)
   ) u_scan (
      .lens(lens), .starts(starts)
   );

   jev_classify #(
      .BLK_WORDS(BLK_WORDS)
   ) u_cls (
      .lens(lens), .starts(starts), .target(req_offset), .fault(fault_c)
   );

   assign req_ready = !rsp_valid;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_fault <= FLT_NONE;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_ok    <= (fault_c == FLT_NONE);
         rsp_fault <= fault_c;
      end else if (rsp_valid && rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/jump_entry_check_chk.sv
module jump_entry_check_chk #(
   parameter int OFS_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [OFS_W-1:0] req_offset,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic             rsp_ok,
   input logic [1:0]       rsp_fault
);
   // R2
   accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R2
   no_accept_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R2
   hold_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ok) && $stable(rsp_fault)));

   // R4
   offset_zero_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_offset == '0) |=> (rsp_ok && rsp_fault == 2'b00));

   // R7
   no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault != 2'b11));

   // R9
   ok_matches_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ok == (rsp_fault == 2'b00)));
endmodule

bind jump_entry_check jump_entry_check_chk #(.OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_ok(rsp_ok), .rsp_fault(rsp_fault)
);

// File: tb/jump_entry_check_test.sv
module jump_entry_check_test;
   localparam int WORD_W = 32;
   localparam int BLKW   = 8;
   localparam int OFSW   = 3;
   localparam int NVEC   = 22;

   // {codes word7..word0 (2 bits each), offset, expected fault}
   localparam logic [20:0] VEC [NVEC] = '{
      {16'b00_00_00_00_00_00_00_00, 3'd5, 2'b00},  // R5 all one-word
      {16'b00_00_00_00_00_00_00_11, 3'd1, 2'b01},  // R6
      {16'b00_00_00_00_00_00_00_11, 3'd2, 2'b01},  // R6
      {16'b00_00_00_00_00_00_00_11, 3'd3, 2'b00},  // R5
      {16'b01_01_01_01_01_11_01_10, 3'd5, 2'b00},  // R3 code 01 is one word
      {16'b01_01_01_01_01_11_01_10, 3'd4, 2'b01},  // R3 R6
      {16'b01_01_01_01_01_11_01_10, 3'd6, 2'b00},  // R3
      {16'b01_01_01_01_01_11_01_10, 3'd1, 2'b01},  // R3 two-word at 0
      {16'b00_11_00_00_00_00_00_00, 3'd6, 2'b10},  // R7 start overruns
      {16'b00_00_11_00_00_00_00_00, 3'd7, 2'b01},  // R6 fits exactly
      {16'b00_00_11_00_00_00_00_00, 3'd5, 2'b00},  // R5
      {16'b10_01_01_01_01_01_01_01, 3'd7, 2'b10},  // R7 two-word at 7
      {16'b00_10_00_00_00_00_00_00, 3'd7, 2'b01},  // R6
      {16'b00_11_00_00_11_00_00_11, 3'd7, 2'b10},  // R7 beats mid
      {16'b11_11_11_11_11_11_11_11, 3'd0, 2'b00},  // R4
      {16'b11_11_11_11_11_11_11_11, 3'd3, 2'b00},  // R5
      {16'b11_11_11_11_11_11_11_11, 3'd7, 2'b10},  // R7
      {16'b10_10_10_10_10_10_10_10, 3'd6, 2'b00},  // R5 ends at word 7
      {16'b10_10_10_10_10_10_10_10, 3'd7, 2'b01},  // R6
      {16'b00_00_00_00_00_00_00_11, 3'd0, 2'b00},  // R4
      {16'b00_00_00_00_00_11_11_11, 3'd3, 2'b00},  // R8 same prefix below
      {16'b11_10_11_10_11_11_11_11, 3'd3, 2'b00}   // R8 tail changed
   };

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   req_valid = 1'b0;
   logic                   req_ready;
   logic [BLKW*WORD_W-1:0] req_words = '0;
   logic [OFSW-1:0]        req_offset = '0;
   logic                   rsp_valid;
   logic                   rsp_ready = 1'b0;
   logic                   rsp_ok;
   logic [1:0]             rsp_fault;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   jump_entry_check uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_words(req_words), .req_offset(req_offset), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [BLKW*WORD_W-1:0] mk_words(input logic [15:0] codes, input int seed);
      logic [BLKW*WORD_W-1:0] w;
      for (int i = 0; i < BLKW; i++)
         w[i*WORD_W +: WORD_W] = {codes[2*i +: 2], 30'(32'h2f5a_3c17 * (seed + i + 1))};
      return w;
   endfunction

   // issue one request; checks response one edge later, takes it after hold cycles
   task automatic run(input string tag, input logic [15:0] codes, input logic [2:0] ofs,
                      input logic [1:0] exp_f, input int seed, input int hold);
      @(negedge clk);
      req_valid  = 1'b1;
      req_words  = mk_words(codes, seed);
      req_offset = ofs;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " fault"}, 32'(rsp_fault), 32'(exp_f));
      check({tag, " ok"}, 32'(rsp_ok), 32'(exp_f == 2'b00));
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check("R2 held valid", 32'(rsp_valid), 32'd1);
         check("R2 ready low", 32'(req_ready), 32'd0);
         check("R2 held fault", 32'(rsp_fault), 32'(exp_f));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check("R2 taken", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1 req_ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++)
         run("R5-table", VEC[v][20:5], VEC[v][4:2], VEC[v][1:0], v * 7, 0);

      // R2: response held while consumer stalls
      run("R2", 16'b00_00_00_00_00_00_00_11, 3'd2, 2'b01, 3, 3);
      // R3: low bits vary, fault unchanged
      run("R3", 16'b00_11_00_00_00_00_00_00, 3'd6, 2'b10, 99, 0);
      run("R3", 16'b00_11_00_00_00_00_00_00, 3'd6, 2'b10, 1234, 0);
      // R8: tail after target altered
      run("R8", 16'b00_00_00_00_00_00_10_10, 3'd4, 2'b00, 5, 0);
      run("R8", 16'b11_11_11_11_00_00_10_10, 3'd4, 2'b00, 6, 0);
      // R6 with R9 ok low
      run("R9", 16'b00_00_00_00_00_11_00_00, 3'd3, 2'b01, 8, 0);

      // R1: reset mid-response clears valid
      @(negedge clk);
      req_valid = 1'b1;
      req_offset = 3'd0;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears valid", 32'(rsp_valid), 32'd0);
      check("R1 reset ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule